// File: doc/BRIEF.md
# Time-Division Multiplexed Frame Transmitter

This block interleaves a fixed set of channels onto a single serial line. Each channel places an 8-bit sample on a wide parallel input. A free-running two-level counter steps through the channels in a fixed order that repeats every frame, and the counter also acts as the select of the output multiplexer. A mode input chooses how the channels share the line. In word mode each slot carries a whole byte, most significant bit first. In bit mode each slot carries a single bit, and eight consecutive frames together carry one byte per channel.

Samples are copied into shadow registers once per sampling period. In word mode the period is one frame of 192 clocks. In bit mode it is a group of eight 24-clock frames, which is also 192 clocks. Input samples and the mode pin may therefore change at any time without disturbing a period that is in progress. The current slot number and a frame-start strobe come out beside the serial bit so that a downstream framer can align to the stream.

Top module: `tdm_frame_tx`

## Requirements
- R1: While reset is asserted, `ser_out` is 0, `frame_start` is 0 and `slot_idx` is 0.
- R2: After reset is released, `ser_out` and `frame_start` stay 0 until the first frame begins, and the first frame begins within 4 clocks.
- R3: `slot_idx` always lies in 0..23. In word mode it holds each value for 8 consecutive clocks, then increments, and wraps from 23 to 0.
- R4: In bit mode `slot_idx` increments on every clock and wraps from 23 to 0.
- R5: `frame_start` is high for exactly the one clock that carries the first bit of slot 0. That is once every 192 clocks in word mode and once every 24 clocks in bit mode.
- R6: In word mode, clock j (0..7) of slot s carries bit 7-j of channel s, where channel s occupies `ch_data[8*s+7 : 8*s]`.
- R7: In bit mode, slot s of frame k (0..7) within an eight-frame group carries bit 7-k of channel s.
- R8: `ch_data` is captured on the last clock edge before each sampling period begins. Changes to `ch_data` during a period have no effect on `ser_out` until the next period.
- R9: The `word_mode` pin (1 = word interleave, 0 = bit interleave) is sampled only at the start of a sampling period. A change during a period alters neither the slot pattern nor the data of that period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| word_mode | input | 1 | 1 selects word interleaving, 0 selects bit interleaving |
| ch_data | input | 192 | 24 channel samples, channel s in bits 8*s+7 down to 8*s |
| ser_out | output | 1 | Serial line output, one bit per clock |
| slot_idx | output | 5 | Slot currently on the line, 0..23 |
| frame_start | output | 1 | One-clock strobe on the first bit of slot 0 |

## Verification
A slot or bit counter that is off by one shows on `slot_idx` or `frame_start` on the clock where it goes wrong. The same fault also puts a bit from the wrong channel or the wrong bit position on `ser_out`, because the counter drives the multiplexer select. A shadow register that loads at the wrong time shows up within the period it corrupts. The bench changes inputs at chosen points inside a period, including its first and last clocks, and compares every output bit against values derived from the channel layout. A mode latch that follows the pin early is exposed on the very next clock, because `slot_idx` begins stepping at the other rate.

// File: rtl/tdm_pkg.sv
package tdm_pkg;
  typedef enum logic {
    ILV_BIT  = 1'b0,
    ILV_WORD = 1'b1
  } ilv_mode_e;
endpackage

// File: rtl/tdm_rst_sync.sv
module tdm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/tdm_slot_seq.sv
module tdm_slot_seq
  import tdm_pkg::*;
#(
  parameter int NUM_CH   = 24,
  parameter int SAMPLE_W = 8,
  localparam int SLOT_W  = (NUM_CH   > 1) ? $clog2(NUM_CH)   : 1,
  localparam int BIT_W   = (SAMPLE_W > 1) ? $clog2(SAMPLE_W) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_pin,
  output logic              running,
  output ilv_mode_e         mode_q,
  output logic [SLOT_W-1:0] slot_q,
  output logic [BIT_W-1:0]  bit_q,
  output logic              period_load
);
  localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(NUM_CH - 1);
  localparam logic [BIT_W-1:0]  BIT_LAST  = BIT_W'(SAMPLE_W - 1);

  logic              run_d;
  ilv_mode_e         mode_d;
  logic [SLOT_W-1:0] slot_d;
  logic [BIT_W-1:0]  bit_d;
  logic              period_end;

  assign period_end  = running && (slot_q == SLOT_LAST) && (bit_q == BIT_LAST);
  assign period_load = !running || period_end;

  always_comb begin
    run_d  = 1'b1;
    mode_d = mode_q;
    slot_d = slot_q;
    bit_d  = bit_q;
    if (period_load) begin
      mode_d = ilv_mode_e'(mode_pin);
      slot_d = '0;
      bit_d  = '0;
    end else if (mode_q == ILV_WORD) begin
      if (bit_q == BIT_LAST) begin
        bit_d  = '0;
        slot_d = slot_q + 1'b1;
      end else begin
        bit_d  = bit_q + 1'b1;
      end
    end else begin
      if (slot_q == SLOT_LAST) begin
        slot_d = '0;
        bit_d  = bit_q + 1'b1;
      end else begin
        slot_d = slot_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      mode_q  <= ILV_WORD;
      slot_q  <= '0;
      bit_q   <= '0;
    end else begin
      running <= run_d;
      mode_q  <= mode_d;
      slot_q  <= slot_d;
      bit_q   <= bit_d;
    end
  end
endmodule

// File: rtl/tdm_shadow_bank.sv
module tdm_shadow_bank #(
  parameter int NUM_CH   = 24,
  parameter int SAMPLE_W = 8,
  localparam int SLOT_W  = (NUM_CH   > 1) ? $clog2(NUM_CH)   : 1,
  localparam int BIT_W   = (SAMPLE_W > 1) ? $clog2(SAMPLE_W) : 1,
  localparam int FLAT_W  = NUM_CH * SAMPLE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [FLAT_W-1:0] samples_in,
  input  logic              out_en,
  input  logic [SLOT_W-1:0] slot_sel,
  input  logic [BIT_W-1:0]  bit_sel,
  output logic [FLAT_W-1:0] shadow_q,
  output logic              bit_out
);
  logic [FLAT_W-1:0]   shadow_d;
  logic [SAMPLE_W-1:0] lane [NUM_CH];
  logic [SAMPLE_W-1:0] lane_sel;
  logic [BIT_W-1:0]    msb_first_idx;

  always_comb begin
    shadow_d = shadow_q;
    if (load_en) shadow_d = samples_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shadow_q <= '0;
    else        shadow_q <= shadow_d;
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_lane
    assign lane[ch] = shadow_q[ch*SAMPLE_W +: SAMPLE_W];
  end

  assign lane_sel      = lane[slot_sel];
  assign msb_first_idx = BIT_W'(SAMPLE_W - 1) - bit_sel;
  assign bit_out       = out_en & lane_sel[msb_first_idx];
endmodule

// File: rtl/tdm_frame_tx.sv
module tdm_frame_tx
  import tdm_pkg::*;
#(
  parameter int NUM_CH   = 24,
  parameter int SAMPLE_W = 8,
  localparam int SLOT_W  = (NUM_CH   > 1) ? $clog2(NUM_CH)   : 1,
  localparam int BIT_W   = (SAMPLE_W > 1) ? $clog2(SAMPLE_W) : 1,
  localparam int FLAT_W  = NUM_CH * SAMPLE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_mode,
  input  logic [FLAT_W-1:0] ch_data,
  output logic              ser_out,
  output logic [SLOT_W-1:0] slot_idx,
  output logic              frame_start
);
  logic              rst_n_sync;
  logic              running;
  ilv_mode_e         mode_q;
  logic [SLOT_W-1:0] slot_q;
  logic [BIT_W-1:0]  bit_q;
  logic              period_load;
  logic [FLAT_W-1:0] shadow_q;

  tdm_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  tdm_slot_seq #(.NUM_CH(NUM_CH), .SAMPLE_W(SAMPLE_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n_sync),
    .mode_pin    (word_mode),
    .running     (running),
    .mode_q      (mode_q),
    .slot_q      (slot_q),
    .bit_q       (bit_q),
    .period_load (period_load)
  );

  tdm_shadow_bank #(.NUM_CH(NUM_CH), .SAMPLE_W(SAMPLE_W)) u_bank (
    .clk        (clk),
    .rst_n      (rst_n_sync),
    .load_en    (period_load),
    .samples_in (ch_data),
    .out_en     (running),
    .slot_sel   (slot_q),
    .bit_sel    (bit_q),
    .shadow_q   (shadow_q),
    .bit_out    (ser_out)
  );

  assign slot_idx    = slot_q;
  assign frame_start = running && (slot_q == '0) &&
                       ((mode_q == ILV_BIT) || (bit_q == '0));
endmodule

// File: rtl/tdm_frame_tx_chk.sv
module tdm_frame_tx_chk
  import tdm_pkg::*;
#(
  parameter int NUM_CH   = 24,
  parameter int SAMPLE_W = 8,
  localparam int SLOT_W  = (NUM_CH   > 1) ? $clog2(NUM_CH)   : 1,
  localparam int BIT_W   = (SAMPLE_W > 1) ? $clog2(SAMPLE_W) : 1,
  localparam int FLAT_W  = NUM_CH * SAMPLE_W
) (
  input logic              clk,
  input logic              rst_n_sync,
  input logic              running,
  input ilv_mode_e         mode_q,
  input logic [SLOT_W-1:0] slot_idx,
  input logic [BIT_W-1:0]  bit_q,
  input logic              period_load,
  input logic [FLAT_W-1:0] shadow_q,
  input logic              ser_out,
  input logic              frame_start
);
  assert_slot_range_R3: assert property (@(posedge clk) disable iff (!rst_n_sync)
    int'(slot_idx) < NUM_CH);

  assert_word_slot_hold_R3: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (running && mode_q == ILV_WORD && !period_load && int'(bit_q) != SAMPLE_W - 1)
      |=> $stable(slot_idx));

  assert_bit_slot_step_R4: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (running && mode_q == ILV_BIT && !period_load && int'(slot_idx) != NUM_CH - 1)
      |=> int'(slot_idx) == int'($past(slot_idx)) + 1);

  assert_start_at_slot0_R5: assert property (@(posedge clk) disable iff (!rst_n_sync)
    frame_start |-> slot_idx == '0);

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n_sync)
    !running |-> (!ser_out && !frame_start));

  assert_shadow_hold_R8: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (running && !period_load) |=> $stable(shadow_q));

  assert_mode_hold_R9: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (running && !period_load) |=> $stable(mode_q));
endmodule

bind tdm_frame_tx tdm_frame_tx_chk #(.NUM_CH(NUM_CH), .SAMPLE_W(SAMPLE_W)) u_chk (
  .clk         (clk),
  .rst_n_sync  (rst_n_sync),
  .running     (running),
  .mode_q      (mode_q),
  .slot_idx    (slot_idx),
  .bit_q       (bit_q),
  .period_load (period_load),
  .shadow_q    (shadow_q),
  .ser_out     (ser_out),
  .frame_start (frame_start)
);

// File: tb/tdm_frame_tx_bench.sv
`timescale 1ns/1ps
module tdm_frame_tx_bench;
  localparam int N  = 24;
  localparam int W  = 8;
  localparam int FW = N * W;
  localparam int PERIOD = N * W;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          word_mode;
  logic [FW-1:0] ch_data;
  logic          ser_out;
  logic [4:0]    slot_idx;
  logic          frame_start;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tdm_frame_tx u_tdm_frame_tx (
    .clk         (clk),
    .rst_n       (rst_n),
    .word_mode   (word_mode),
    .ch_data     (ch_data),
    .ser_out     (ser_out),
    .slot_idx    (slot_idx),
    .frame_start (frame_start)
  );

  function automatic logic [FW-1:0] pattern(int seed);
    logic [FW-1:0] v;
    for (int ch = 0; ch < N; ch++) v[ch*W +: W] = 8'((ch * 37 + seed * 11 + 5) & 255);
    return v;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Checks one sampling period cycle by cycle; t = 0 is the first clock of the period.
  task automatic run_period(input logic [FW-1:0] d, input logic m, input int chg_t,
                            input logic [FW-1:0] nd, input logic nm);
    for (int t = 0; t < PERIOD; t++) begin
      int s, b, e_fs, e_ser;
      if (m) begin s = t / W; b = t % W; e_fs = (t == 0); end
      else   begin s = t % N; b = t / N; e_fs = (s == 0); end
      e_ser = int'(d[s*W + (W-1-b)]);
      check(int'(slot_idx) == s, m ? "R3" : "R4", "slot_idx", int'(slot_idx), s);
      check(int'(frame_start) == e_fs, "R5", "frame_start", int'(frame_start), e_fs);
      check(int'(ser_out) == e_ser, m ? "R6" : "R7", "ser_out", int'(ser_out), e_ser);
      if (t == chg_t) begin
        ch_data   = nd;
        word_mode = nm;
      end
      @(negedge clk);
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int waited;
    rst_n     = 1'b0;
    word_mode = 1'b1;
    ch_data   = pattern(1);
    repeat (4) begin
      @(negedge clk);
      check(ser_out == 1'b0, "R1", "ser_out in reset", int'(ser_out), 0);
      check(frame_start == 1'b0, "R1", "frame_start in reset", int'(frame_start), 0);
      check(slot_idx == 5'd0, "R1", "slot_idx in reset", int'(slot_idx), 0);
    end
    rst_n = 1'b1;
    waited = 0;
    @(negedge clk);
    while (!frame_start && waited < 6) begin
      check(ser_out == 1'b0, "R2", "ser_out before first frame", int'(ser_out), 0);
      waited++;
      @(negedge clk);
    end
    check(waited <= 4, "R2", "clocks to first frame", waited, 4);

    // R6 R8: word mode, data changed mid-period must not show until next period
    run_period(pattern(1), 1'b1, 50, pattern(2), 1'b1);
    // R9: mode pin flips to bit mode mid-period; takes effect next period
    run_period(pattern(2), 1'b1, 100, pattern(3), 1'b0);
    // R7 R8: bit mode with early input change
    run_period(pattern(3), 1'b0, 10, pattern(4), 1'b0);
    // R8 R9: change on the last clock of a period is captured for the next one
    run_period(pattern(4), 1'b0, PERIOD - 1, {FW{1'b1}}, 1'b1);
    // all-ones word period, then change on its first clock
    run_period({FW{1'b1}}, 1'b1, 0, '0, 1'b0);
    run_period('0, 1'b0, 0, pattern(7), 1'b1);
    run_period(pattern(7), 1'b1, -1, '0, 1'b1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule